// File: doc/BRIEF.md
# Configurable LUT Logic Element

This block is one programmable logic cell of a small island-style fabric. Four data inputs address a 16-entry truth table, so the cell can form any Boolean function of those inputs. The table result drives the single cell output directly, or passes through one flip-flop first. A configuration bit picks between the two paths.

The table contents and the path-select bit together form a 17-bit configuration word. The word is shifted in serially, one bit per clock, while the configuration enable is high. When the enable is low, the configuration cannot change, and the cell runs as user logic. A serial output carries the bit that leaves the chain next, so the chains of several cells can be joined end to end and loaded as one long chain. The clock comes from a dedicated global network and is not part of the general routing. The synchronous reset clears only the flip-flop.

Top module: `lut_cell`

## Requirements
- R1: With the select bit at 0, `dout` equals table bit i in the same cycle, where i = 8*din[3] + 4*din[2] + 2*din[1] + din[0].
- R2: With the select bit at 1, `dout` is the flip-flop. On every rising edge where `rst` is low, the flip-flop loads the table output formed from `din` and the table contents just before that edge. This includes edges where the chain shifts.
- R3: Seventeen edges with `cfg_en` high load a word most significant bit first. The first bit shifted in becomes the select bit. The bits that follow become table bits 15 down to 0, and table bit i is the output for index i as defined in R1.
- R4: On an edge with `cfg_en` low, the table and the select bit keep their values, and `cfg_dout` does not change.
- R5: `cfg_dout` always shows the most significant chain bit, which is the current select bit. Each enabled edge moves the bit below it into that place. As a result, the previously stored word leaves the cell most significant bit first, which allows cells to be daisy-chained.
- R6: An edge with `rst` high clears the flip-flop, so in registered mode `dout` is 0 afterwards. The configuration bits are not affected by reset.
- R7: When `rst` and `cfg_en` are both high at the same edge, the flip-flop clears and the chain shifts, both in that one edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock from the dedicated global network |
| rst | input | 1 | Synchronous reset of the flip-flop, active high |
| cfg_en | input | 1 | Configuration shift enable, active high |
| cfg_din | input | 1 | Serial configuration data in |
| din | input | 4 | Table address inputs; din[3] is the most significant |
| dout | output | 1 | Cell output, combinational or registered |
| cfg_dout | output | 1 | Serial configuration data out, toward the next cell |

## Verification
Two functions can share one edge. A configuration shift can coincide with the flip-flop capture, and it can coincide with a reset of the flip-flop. The bench provokes the first case by shifting words while the registered path is selected and `din` varies at random. It provokes the second by holding `rst` high during whole loads and during random stretches. A reference model captures the pre-edge table into the flip-flop, or clears it on reset, and shifts the chain in the same step. Each cycle, `dout` and `cfg_dout` are compared with that model, which shows whether both effects landed in the same edge.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;

  typedef enum logic {
    OUT_COMB = 1'b0,
    OUT_REG  = 1'b1
  } out_sel_e;

  // Picks one truth-table entry; tables up to 64 entries fit.
  function automatic logic lut_pick(input logic [63:0] tbl, input logic [5:0] idx);
    return tbl[idx];
  endfunction

endpackage

// File: rtl/lut_table.sv
module lut_table #(
  parameter int unsigned K = 4,
  localparam int unsigned N = 2**K
) (
  input  logic [N-1:0] tbl,
  input  logic [K-1:0] idx,
  output logic         y
);

  // Binary mux tree: level l halves the candidates using idx[l-1].
  for (genvar l = 0; l <= K; l++) begin : g_lvl
    localparam int unsigned W = 2**(K-l);
    logic [W-1:0] v;
    if (l == 0) begin : g_leaf
      assign v = tbl;
    end else begin : g_node
      for (genvar j = 0; j < W; j++) begin : g_mux
        assign v[j] = idx[l-1] ? g_lvl[l-1].v[2*j+1] : g_lvl[l-1].v[2*j];
      end
    end
  end

  assign y = g_lvl[K].v[0];

endmodule

// File: rtl/lut_cfg_chain.sv
module lut_cfg_chain #(
  parameter int unsigned W = 17
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_en,
  input  logic         cfg_din,
  output logic [W-1:0] word,
  output logic         cfg_dout
);

  logic [W-1:0] chain_q;

  // No reset: configuration survives the user reset.
  always_ff @(posedge clk) begin
    if (cfg_en) chain_q <= {chain_q[W-2:0], cfg_din};
  end

  assign word     = chain_q;
  assign cfg_dout = chain_q[W-1];

  // R4: without enable nothing in the configuration moves
  assert_cfg_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> $stable(word));

  // R5: next serial bit is the one that sat just below the top
  assert_serial_order_R5: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> cfg_dout == $past(word[W-2]));

endmodule

// File: rtl/lut_out_stage.sv
module lut_out_stage
  import lut_cell_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     d,
  input  out_sel_e sel,
  output logic     ff_q,
  output logic     dout
);

  always_ff @(posedge clk) begin
    if (rst) ff_q <= 1'b0;
    else     ff_q <= d;
  end

  assign dout = (sel == OUT_REG) ? ff_q : d;

  // R6: an edge in reset leaves the flip-flop at zero
  assert_ff_cleared_R6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ff_q == 1'b0);

endmodule

// File: rtl/lut_cell.sv
module lut_cell
  import lut_cell_pkg::*;
#(
  parameter int unsigned LUT_K = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic             cfg_din,
  input  logic [LUT_K-1:0] din,
  output logic             dout,
  output logic             cfg_dout
);

  localparam int unsigned TBL_W   = 2**LUT_K;
  localparam int unsigned CHAIN_W = TBL_W + 1;

  logic [CHAIN_W-1:0] cfg_word;
  logic [TBL_W-1:0]   tbl;
  out_sel_e           out_sel;
  logic               lut_y;
  logic               ff_q;

  lut_cfg_chain #(.W(CHAIN_W)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .cfg_en   (cfg_en),
    .cfg_din  (cfg_din),
    .word     (cfg_word),
    .cfg_dout (cfg_dout)
  );

  // Word layout: top bit selects the output path, the rest is the table.
  assign tbl     = cfg_word[TBL_W-1:0];
  assign out_sel = out_sel_e'(cfg_word[CHAIN_W-1]);

  lut_table #(.K(LUT_K)) u_table (
    .tbl (tbl),
    .idx (din),
    .y   (lut_y)
  );

  lut_out_stage u_out (
    .clk  (clk),
    .rst  (rst),
    .d    (lut_y),
    .sel  (out_sel),
    .ff_q (ff_q),
    .dout (dout)
  );

  // R1: combinational path returns the addressed table entry
  assert_comb_lookup_R1: assert property (@(posedge clk) disable iff (rst)
    out_sel == OUT_COMB |-> dout == lut_pick(64'(tbl), 6'(din)));

  // R2: registered path returns the table result of the previous edge
  assert_reg_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && out_sel == OUT_REG) |-> dout == $past(lut_y));

  // R7: reset and shift together: flop cleared and chain advanced
  assert_rst_and_shift_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && $past(cfg_en)) |-> (ff_q == 1'b0 && cfg_dout == $past(cfg_word[CHAIN_W-2])));

endmodule

// File: tb/lut_cell_tb.sv
module lut_cell_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_en = 1'b0;
  logic       cfg_din = 1'b0;
  logic [3:0] din = 4'd0;
  logic       dout;
  logic       cfg_dout;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;

  // Reference model
  logic [16:0] mword = '0;
  logic        mff   = 1'b0;
  int unsigned shifts = 0;
  bit          known  = 0;
  logic        prev_rst = 1'b1;
  logic        prev_cfg = 1'b0;
  bit          probe_en = 0;
  logic        probe_exp = 1'b0;

  always #2.5 clk = ~clk;

  lut_cell u_dut (
    .clk      (clk),
    .rst      (rst),
    .cfg_en   (cfg_en),
    .cfg_din  (cfg_din),
    .din      (din),
    .dout     (dout),
    .cfg_dout (cfg_dout)
  );

  function automatic logic ref_lookup(input logic [16:0] w, input logic [3:0] d);
    int unsigned pos;
    pos = (d[3] ? 8 : 0) + (d[2] ? 4 : 0) + (d[1] ? 2 : 0) + (d[0] ? 1 : 0);
    return w[pos];
  endfunction

  function automatic logic ref_out(input logic [16:0] w, input logic ff, input logic [3:0] d);
    return w[16] ? ff : ref_lookup(w, d);
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cycle(input logic r, input logic ce, input logic cd, input logic [3:0] d);
    string dtag;
    string ctag;
    logic  nff;
    @(negedge clk);
    rst = r; cfg_en = ce; cfg_din = cd; din = d;
    #1;
    if (known) begin
      if (!mword[16])              dtag = "R1";
      else if (prev_rst && prev_cfg) dtag = "R7";
      else if (prev_rst)           dtag = "R6";
      else                         dtag = "R2";
      if (prev_rst && prev_cfg)    ctag = "R7";
      else if (prev_cfg)           ctag = "R5";
      else                         ctag = "R4";
      check(dtag, dout, ref_out(mword, mff, d));
      check(ctag, cfg_dout, mword[16]);
      if (probe_en) check("R3", dout, probe_exp);
    end
    @(posedge clk);
    nff = r ? 1'b0 : ref_lookup(mword, d);
    if (ce) begin
      mword = {mword[15:0], cd};
      shifts++;
    end
    mff = nff;
    prev_rst = r;
    prev_cfg = ce;
    if (shifts >= 17) known = 1;
  endtask

  task automatic load(input logic r, input logic [16:0] w);
    for (int i = 16; i >= 0; i--) cycle(r, 1'b1, w[i], 4'($urandom));
  endtask

  // Sweep all addresses in combinational mode and compare against the word.
  task automatic sweep(input logic [16:0] w);
    for (int i = 0; i < 16; i++) begin
      probe_en  = 1;
      probe_exp = w[i];
      cycle(1'b0, 1'b0, 1'b0, 4'(i));
    end
    probe_en = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [16:0] w;
    void'($urandom(32'd5150));
    // R7 / R6: load registered mode entirely under reset
    load(1'b1, {1'b1, 16'hA5C3});
    cycle(1'b1, 1'b0, 1'b0, 4'hF);
    cycle(1'b0, 1'b0, 1'b0, 4'h0);   // reset state: flop cleared (R6)
    // R2: registered operation
    for (int i = 0; i < 20; i++) cycle(1'b0, 1'b0, 1'b0, 4'($urandom));
    // R3/R1: four-input AND, combinational
    load(1'b0, {1'b0, 16'h8000});
    sweep({1'b0, 16'h8000});
    // parity function
    load(1'b0, {1'b0, 16'h6996});
    sweep({1'b0, 16'h6996});
    // R4: long idle stretch with toggling data input
    for (int i = 0; i < 40; i++) cycle(1'b0, 1'b0, $urandom, 4'($urandom));
    sweep({1'b0, 16'h6996});
    // R5: shifting a new word pushes the old one out MSB first
    load(1'b0, {1'b1, 16'h0F0F});
    load(1'b0, {1'b1, 16'hFFFF});
    // R6 mid-run reset in registered mode
    cycle(1'b1, 1'b0, 1'b0, 4'hF);
    cycle(1'b0, 1'b0, 1'b0, 4'hF);
    cycle(1'b0, 1'b0, 1'b0, 4'h0);
    // Random mixing of all functions
    for (int k = 0; k < 30; k++) begin
      w = 17'($urandom);
      load(($urandom % 4) == 0, w);
      for (int i = 0; i < 25; i++)
        cycle(($urandom % 10) == 0, ($urandom % 8) == 0, $urandom, 4'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule